// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock by a programmable ratio M and gives one output pulse for every M input cycles. The pulse is meant to feed a phase/frequency detector. The ratio is built from a dual-modulus prescaler that divides by 64 or by 65. A 6-bit swallow count A and a 12-bit main count B control the modulus. During each output period the prescaler divides by 65 for the first A of its carries. It then divides by 64 for the remaining B − A carries. The total is M = 65·A + 64·(B − A) = 64·B + A.

The divide word is 18 bits wide. An update strobe captures it at any time. The captured value becomes active only at the next output-period boundary, so a period already under way finishes with the ratio it started with. A run input that is held low puts the block in stand-by. In stand-by the counters are held at zero and no pulses are produced. The captured word is kept, and counting starts cleanly when run returns high. The prescaler is modelled as synchronous logic clocked by the input clock.

Top module: `swallow_divider`

## Requirements
- R1: While rst_n is low, div_pulse is low. After reset the active ratio is the reset word (default B = 63, A = 0, so M = 4032). div_pulse is first high in the cycle after the M-th rising edge that samples rst_n high.
- R2: With a steady word, consecutive div_pulse assertions are exactly M = 64·B + A input-clock cycles apart.
- R3: div_pulse is high for exactly one input-clock cycle per period.
- R4: Within a period the prescaler divides by 65 for the first A prescaler carries and by 64 for every carry after that. It never counts past 65 states.
- R5: A word captured by load in the middle of a period does not change that period. It sets the length of the next period and of every later one.
- R6: If the programmed B is less than A, B is treated as equal to A, so M = 65·A.
- R7: If both B and A are zero, B is treated as 1, so M = 64.
- R8: While run is low, the counters are held at zero and div_pulse stays low. A word loaded during stand-by is active from the release. The first pulse comes M edges after run is first sampled high.
- R9: The divide word carries B in bits 17:6 and A in bits 5:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | High for normal counting, low for stand-by |
| div_word | input | 18 | Divide word: B in bits 17:6, A in bits 5:0 |
| load | input | 1 | Captures div_word on a rising clock edge |
| div_pulse | output | 1 | One-cycle pulse once per M input cycles |

## Verification
The period is measured by counting input edges between pulses. It is compared with 64·B + A for random legal words and for directed edge words: A = 0, A = 63, B = 1, B below A, and an all-zero word. Random words tell a correct field split apart from swapped or shifted fields. The words with A = 0 and A = 63 separate a correct swallow phase from one that is too short or too long. The clamped words expose any missing handling of B < A and B = 0. The period that runs while a new word is loaded is also measured, which shows whether an update leaks into the running cycle. A stand-by run with a word loaded during it shows whether counters are reset and the latched word is applied on release.

// File: rtl/swd_pkg.sv
// Package for the pulse-swallow divider: field widths, ratio type and the
// word sanitising function shared by the latch and the checker.
package swd_pkg;

    localparam int A_W   = 6;          // swallow count width
    localparam int B_W   = 12;         // main count width
    localparam int W_W   = A_W + B_W;  // divide word width
    localparam int P_DIV = 1 << A_W;   // low prescaler modulus (64)

    // Active ratio as held by the divider
    typedef struct packed {
        logic [B_W-1:0] main_n;
        logic [A_W-1:0] swal_n;
    } ratio_t;

    // Splits a raw word and applies the B>=A and B>=1 rules
    function automatic ratio_t sanitize(input logic [W_W-1:0] w);
        ratio_t r;
        r.swal_n = w[A_W-1:0];
        r.main_n = w[W_W-1:A_W];
        if (r.main_n < B_W'(r.swal_n)) r.main_n = B_W'(r.swal_n);
        if (r.main_n == '0)            r.main_n = B_W'(1);
        return r;
    endfunction

endpackage

// File: rtl/swd_ratio_latch.sv
// Holds the pending divide word and the active ratio.
// Assumes: boundary pulses on the last input cycle of a period; while run is
// low the counters are idle, so the active ratio follows the pending one.
module swd_ratio_latch
    import swd_pkg::*;
#(
    parameter logic [B_W-1:0] RESET_B = 12'd63,
    parameter logic [A_W-1:0] RESET_A = 6'd0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           load,
    input  logic [W_W-1:0] word,
    input  logic           boundary,
    output ratio_t         act
);
    localparam ratio_t RESET_R = '{main_n: RESET_B, swal_n: RESET_A};

    ratio_t pend;

    // Capture the sanitised word on each load strobe
    always_ff @(posedge clk) begin
        if (!rst_n)    pend <= RESET_R;
        else if (load) pend <= sanitize(word);
    end

    // Transfer to the active ratio at a period boundary or in stand-by
    always_ff @(posedge clk) begin
        if (!rst_n)                  act <= RESET_R;
        else if (!run || boundary)   act <= load ? sanitize(word) : pend;
    end
endmodule

// File: rtl/swd_prescaler.sv
// Dual-modulus prescaler modelled synchronously: counts P or P+1 input
// cycles per carry depending on use_high. Assumes mode changes only on carry.
module swd_prescaler
    import swd_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         use_high,
    output logic         tick,
    output logic [A_W:0] cnt
);
    localparam logic [A_W:0] LAST_LO = (A_W+1)'(P_DIV - 1);
    localparam logic [A_W:0] LAST_HI = (A_W+1)'(P_DIV);

    // Carry on the last state of the current modulus
    always_comb tick = (cnt == (use_high ? LAST_HI : LAST_LO));

    // Count input cycles, wrap on carry, clear in stand-by
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/swd_modulus_ctrl.sv
// Swallow and main counters: select the prescaler modulus, find the period
// boundary and register the output pulse.
// Assumes act is stable within a period (held by swd_ratio_latch) and B >= A >= 0, B >= 1.
module swd_modulus_ctrl
    import swd_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           tick,
    input  ratio_t         act,
    output logic           use_high,
    output logic           boundary,
    output logic [B_W-1:0] main_cnt,
    output logic           pulse
);
    logic [B_W-1:0] swal_cnt;
    logic           last_main;

    // Modulus select and end-of-period detect
    always_comb begin
        use_high  = swal_cnt < B_W'(act.swal_n);
        last_main = main_cnt == (act.main_n - 1'b1);
        boundary  = tick && last_main;
    end

    // Count prescaler carries for both counters, restart at the boundary
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            main_cnt <= '0;
            swal_cnt <= '0;
        end else if (boundary) begin
            main_cnt <= '0;
            swal_cnt <= '0;
        end else if (tick) begin
            main_cnt <= main_cnt + 1'b1;
            swal_cnt <= swal_cnt + 1'b1;
        end
    end

    // One-cycle output pulse after the boundary edge
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pulse <= 1'b0;
        else                pulse <= boundary;
    end
endmodule

// File: rtl/swallow_divider.sv
// Top of the pulse-swallow divider: M = 64*B + A, word = {B, A}.
// Assumes a single input clock domain; stand-by via run low.
module swallow_divider
    import swd_pkg::*;
#(
    parameter logic [B_W-1:0] RESET_B = 12'd63,
    parameter logic [A_W-1:0] RESET_A = 6'd0
) (
    input  logic           clk_in,
    input  logic           rst_n,
    input  logic           run,
    input  logic [W_W-1:0] div_word,
    input  logic           load,
    output logic           div_pulse
);
    ratio_t         act_ratio;
    logic           pre_tick;
    logic [A_W:0]   pre_cnt;
    logic           use_high;
    logic           boundary;
    logic [B_W-1:0] ctl_main;

    swd_ratio_latch #(.RESET_B(RESET_B), .RESET_A(RESET_A)) u_latch (
        .clk(clk_in), .rst_n(rst_n), .run(run), .load(load),
        .word(div_word), .boundary(boundary), .act(act_ratio)
    );

    swd_prescaler u_pre (
        .clk(clk_in), .rst_n(rst_n), .run(run), .use_high(use_high),
        .tick(pre_tick), .cnt(pre_cnt)
    );

    swd_modulus_ctrl u_ctl (
        .clk(clk_in), .rst_n(rst_n), .run(run), .tick(pre_tick),
        .act(act_ratio), .use_high(use_high), .boundary(boundary),
        .main_cnt(ctl_main), .pulse(div_pulse)
    );
endmodule

// File: rtl/swd_checker.sv
// Property checker for swallow_divider, attached by bind.
module swd_checker
    import swd_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           run,
    input logic           div_pulse,
    input logic           tick,
    input logic           use_high,
    input logic [A_W:0]   pc,
    input logic [B_W-1:0] main_cnt,
    input logic [B_W-1:0] b_act
);
    assert_single_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    assert_standby_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !div_pulse);

    assert_prescale_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pc <= (A_W+1)'(P_DIV)) && ((pc == (A_W+1)'(P_DIV)) -> use_high));

    assert_mode_on_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(use_high) && run && $past(run)) |-> $past(tick));

    assert_main_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        main_cnt < b_act);
endmodule

bind swallow_divider swd_checker u_chk (
    .clk(clk_in), .rst_n(rst_n), .run(run), .div_pulse(div_pulse),
    .tick(pre_tick), .use_high(use_high), .pc(pre_cnt),
    .main_cnt(ctl_main), .b_act(act_ratio.main_n)
);

// File: tb/swallow_divider_test.sv
module swallow_divider_test;
    logic        clk_in = 1'b0;
    logic        rst_n  = 1'b0;
    logic        run    = 1'b1;
    logic [17:0] div_word = '0;
    logic        load   = 1'b0;
    logic        div_pulse;

    int checks = 0;
    int fails  = 0;

    swallow_divider uut (
        .clk_in(clk_in), .rst_n(rst_n), .run(run),
        .div_word(div_word), .load(load), .div_pulse(div_pulse)
    );

    always #2 clk_in = ~clk_in;   // 250 MHz

    function automatic int exp_m(input logic [17:0] w);
        int a = int'(w[5:0]);
        int b = int'(w[17:6]);
        if (b < a) b = a;
        if (b == 0) b = 1;
        return 64 * b + a;
    endfunction

    function automatic logic [17:0] mk(input int b, input int a);
        return {12'(b), 6'(a)};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count rising edges until div_pulse is seen high at a falling edge
    task automatic measure(output int n);
        n = 0;
        do begin
            @(posedge clk_in);
            n++;
            @(negedge clk_in);
            load = 1'b0;
        end while (!div_pulse && n < 300000);
    endtask

    // Load a word just after a pulse; check old period, then new period
    task automatic apply(input logic [17:0] w, input int old_m, input string req);
        int n;
        div_word = w;
        load = 1'b1;
        measure(n);
        check("R5 old ratio holds", n, old_m);
        measure(n);
        check(req, n, exp_m(w));
    endtask

    initial begin
        int n;
        int cur;
        int seen;
        void'($urandom(32'h5EED_0042));
        repeat (5) @(negedge clk_in);
        check("R1 pulse low in reset", int'(div_pulse), 0);
        rst_n = 1'b1;
        measure(n);
        check("R1 first period after reset", n, 4032);
        measure(n);
        check("R2 steady reset word", n, 4032);
        cur = 4032;

        apply(mk(1, 0), cur, "R2 B=1 A=0");            cur = 64;
        apply(mk(1, 1), cur, "R4 B=1 A=1");            cur = 65;
        apply(mk(0, 0), cur, "R7 zero word");          cur = 64;
        apply(mk(5, 40), cur, "R6 B below A");         cur = 2600;
        apply(mk(63, 63), cur, "R4 full swallow");     cur = 4095;
        apply(mk(2, 1), cur, "R2 B=2 A=1");            cur = 129;
        apply(mk(64, 1), cur, "R9 field split");       cur = 4097;
        measure(n);
        check("R3 single pulse per period", n, 4097);

        for (int i = 0; i < 8; i++) begin
            int b = 63 + int'($urandom_range(0, 9));
            int a = int'($urandom_range(0, 63));
            apply(mk(b, a), cur, "R2 R9 random word");
            cur = 64 * b + a;
        end

        // Stand-by with a word loaded while stopped
        run = 1'b0;
        @(negedge clk_in);
        div_word = mk(64, 7);
        load = 1'b1;
        @(negedge clk_in);
        load = 1'b0;
        seen = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk_in);
            if (div_pulse) seen++;
        end
        check("R8 no pulse in stand-by", seen, 0);
        run = 1'b1;
        measure(n);
        check("R8 first period after release", n, 4103);
        measure(n);
        check("R8 steady after release", n, 4103);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk_in);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule